// File: doc/BRIEF.md
# Byte-Lane Static RAM with Mode Decode

This block is a clock-sampled model of a 16-bit-wide static memory with active-low controls: a chip select, a write strobe, a read strobe and one enable per byte lane. On every rising clock edge it decodes these controls into one of four operating modes: deselect, read, write or output-disabled. It then either updates the selected lanes of the addressed word or presents the stored lanes on a registered data output.

The data path is split into a 16-bit input bus, a 16-bit output bus and a per-lane output-enable pair. A bidirectional pad ring outside the block can combine these into a real tri-state bus. The depth is set by an address-width parameter, which is scaled down for simulation. A standby flag and a two-bit mode code report the decoded mode.

Top module: `byteLaneSram`

## Requirements
- R1: After reset, `standby` is 1, `mode` is 0, `laneOe` is 00 and `dataOut` is 0.
- R2: When `ceN` is 1 at a clock edge, the next cycle shows `mode` 0 (deselect), `standby` 1 and `laneOe` 00, and nothing is written whatever `weN`, `oeN` and the byte enables are.
- R3: When `ceN` is 0 but both `lbN` and `hbN` are 1, the block deselects exactly as in R2, and a low `weN` writes nothing.
- R4: When `ceN`=0, `weN`=1 and `oeN`=0 at an edge, the next cycle shows `mode` 1 (read) and `standby` 0. Each lane whose enable is 0 raises its `laneOe` bit and drives the stored byte of `addr`.
- R5: During a read, a lane whose enable is 1 keeps its `laneOe` bit at 0, and its byte of `dataOut` is 0. Any lane with `laneOe` low always shows 0.
- R6: When `ceN`=0 and `weN`=0 with at least one byte enable low, the next cycle shows `mode` 2 (write) and `laneOe` 00 whatever `oeN` is. Lanes with enable 0 take `dataIn`, and lanes with enable 1 keep their old contents.
- R7: When `ceN`=0, `weN`=1 and `oeN`=1 with at least one byte enable low, the next cycle shows `mode` 3 (output-disabled), `standby` 0 and `laneOe` 00.
- R8: `standby` is 1 exactly when `mode` is 0.
- R9: Every word holds `FILL_WORD` (default 16'h5AC3) at power-up, and a lane that was never written reads back its fill byte.
- R10: Lane 0 is bits 7:0 and is gated by `lbN`. Lane 1 is bits 15:8 and is gated by `hbN`. `laneOe[0]` and `laneOe[1]` follow the same lane numbering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low reset of the output registers |
| ceN | input | 1 | Active-low chip select |
| weN | input | 1 | Active-low write strobe |
| oeN | input | 1 | Active-low read strobe |
| lbN | input | 1 | Active-low enable of lane 0 (bits 7:0) |
| hbN | input | 1 | Active-low enable of lane 1 (bits 15:8) |
| addr | input | ADDR_W | Word address |
| dataIn | input | 16 | Write data |
| dataOut | output | 16 | Registered read data, zero in undriven lanes |
| laneOe | output | 2 | Registered per-lane drive enable |
| standby | output | 1 | Registered deselect flag |
| mode | output | 2 | Registered mode: 0 deselect, 1 read, 2 write, 3 output-disabled |

## Verification
A write strobe and a read strobe can be asserted in the same cycle. The bench provokes this by issuing writes with `oeN` held low, including partial-lane writes. The result is judged in two steps. First, in the following cycle `mode` must be 2 and both `laneOe` bits must be 0, so the write has won. Second, a later read of the same word must return the merged lanes. Because the bench's own reference array predicts each result, a write that leaks onto the output and a write that is lost both show up.

// File: rtl/byteSramPkg.sv
package byteSramPkg;

  typedef enum logic [1:0] {
    MODE_DESEL = 2'd0,
    MODE_READ  = 2'd1,
    MODE_WRITE = 2'd2,
    MODE_OFF   = 2'd3
  } modeT;

  // Strobes from the control decode to the storage datapath
  typedef struct packed {
    modeT mode;
    logic wrEn;
    logic rdEn;
  } strobeT;

endpackage

// File: rtl/byteSramCtrl.sv
module byteSramCtrl
  import byteSramPkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ceN,
  input  logic             weN,
  input  logic             oeN,
  input  logic [LANES-1:0] byteN,
  output strobeT           stb,
  output logic [LANES-1:0] laneSel,
  output modeT             modeQ,
  output logic             standbyQ
);

  logic lanesOff;
  logic deselect;
  modeT modeD;

  assign lanesOff = &byteN;
  assign deselect = ceN | lanesOff;

  always_comb begin
    if (deselect)  modeD = MODE_DESEL;
    else if (!weN) modeD = MODE_WRITE;   // write strobe overrides read strobe
    else if (!oeN) modeD = MODE_READ;
    else           modeD = MODE_OFF;
  end

  always_comb begin
    stb.mode = modeD;
    stb.wrEn = (modeD == MODE_WRITE);
    stb.rdEn = (modeD == MODE_READ);
    laneSel  = deselect ? '0 : ~byteN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ    <= MODE_DESEL;
      standbyQ <= 1'b1;
    end else begin
      modeQ    <= modeD;
      standbyQ <= deselect;
    end
  end

  p_ce_desel_r2: assert property (@(posedge clk) disable iff (!rstN)
    ceN |=> (modeQ == MODE_DESEL && standbyQ));

  p_byte_desel_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && lanesOff) |=> (standbyQ && modeQ == MODE_DESEL));

  p_write_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && !weN && !lanesOff) |=> (modeQ == MODE_WRITE));

  p_out_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && weN && oeN && !lanesOff) |=> (modeQ == MODE_OFF && !standbyQ));

  p_standby_mode_r8: assert property (@(posedge clk) disable iff (!rstN)
    standbyQ == (modeQ == MODE_DESEL));

endmodule

// File: rtl/byteSramData.sv
module byteSramData
  import byteSramPkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          LANES     = 2,
  parameter logic [15:0] FILL_WORD = 16'h5AC3
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             stb,
  input  logic [LANES-1:0]   laneSel,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [LANES*8-1:0] dataIn,
  output logic [LANES*8-1:0] dataOut,
  output logic [LANES-1:0]   laneOe
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] laneMem [DEPTH];
    logic       wrLane;
    logic       rdLane;

    assign wrLane = stb.wrEn & laneSel[g];
    assign rdLane = stb.rdEn & laneSel[g];

    initial begin
      for (int i = 0; i < DEPTH; i++) laneMem[i] = FILL_WORD[g*8 +: 8];
    end

    always_ff @(posedge clk) begin
      if (wrLane) laneMem[addr] <= dataIn[g*8 +: 8];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dataOut[g*8 +: 8] <= '0;
        laneOe[g]         <= 1'b0;
      end else begin
        dataOut[g*8 +: 8] <= rdLane ? laneMem[addr] : 8'h00;
        laneOe[g]         <= rdLane;
      end
    end

    p_idle_lane_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
      !laneOe[g] |-> (dataOut[g*8 +: 8] == 8'h00));
  end

  p_write_no_drive_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrEn |=> (laneOe == '0));

  p_read_lanes_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdEn |=> (laneOe == $past(laneSel)));

endmodule

// File: rtl/byteLaneSram.sv
module byteLaneSram
  import byteSramPkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter logic [15:0] FILL_WORD = 16'h5AC3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic              lbN,
  input  logic              hbN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       dataIn,
  output logic [15:0]       dataOut,
  output logic [1:0]        laneOe,
  output logic              standby,
  output logic [1:0]        mode
);

  localparam int LANES = 2;

  strobeT           stb;
  logic [LANES-1:0] laneSel;
  modeT             modeQ;

  byteSramCtrl #(.LANES(LANES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ceN      (ceN),
    .weN      (weN),
    .oeN      (oeN),
    .byteN    ({hbN, lbN}),
    .stb      (stb),
    .laneSel  (laneSel),
    .modeQ    (modeQ),
    .standbyQ (standby)
  );

  byteSramData #(.ADDR_W(ADDR_W), .LANES(LANES), .FILL_WORD(FILL_WORD)) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .laneSel (laneSel),
    .addr    (addr),
    .dataIn  (dataIn),
    .dataOut (dataOut),
    .laneOe  (laneOe)
  );

  assign mode = modeQ;

endmodule

// File: tb/byteLaneSram_tb.sv
module byteLaneSram_tb;

  localparam int          ADDR_W = 8;
  localparam int          DEPTH  = 1 << ADDR_W;
  localparam logic [15:0] FILL   = 16'h5AC3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, weN = 1'b1, oeN = 1'b1, lbN = 1'b1, hbN = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [15:0] dataIn = '0;
  logic [15:0] dataOut;
  logic [1:0]  laneOe;
  logic        standby;
  logic [1:0]  mode;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    logic [1:0]  mode;
    logic [1:0]  oe;
    logic [15:0] data;
    string       tag;
  } expT;

  expT        sb[$];
  logic [15:0] ref_mem [DEPTH];

  always #2 clk = ~clk;

  byteLaneSram #(.ADDR_W(ADDR_W), .FILL_WORD(FILL)) u_dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .lbN(lbN), .hbN(hbN), .addr(addr), .dataIn(dataIn),
    .dataOut(dataOut), .laneOe(laneOe), .standby(standby), .mode(mode)
  );

  task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus, expected result pushed to the scoreboard
  task automatic op(logic c, logic w, logic o, logic l, logic h,
                    logic [ADDR_W-1:0] a, logic [15:0] d, string tag);
    expT e;
    logic desel;
    @(negedge clk);
    ceN = c; weN = w; oeN = o; lbN = l; hbN = h; addr = a; dataIn = d;
    desel = c | (l & h);
    e.tag  = tag;
    e.oe   = 2'b00;
    e.data = 16'h0000;
    if (desel) e.mode = 2'd0;
    else if (!w) begin
      e.mode = 2'd2;
      if (!l) ref_mem[a][7:0]  = d[7:0];
      if (!h) ref_mem[a][15:8] = d[15:8];
    end else if (!o) begin
      e.mode = 2'd1;
      e.oe   = {~h, ~l};
      e.data = {h ? 8'h00 : ref_mem[a][15:8], l ? 8'h00 : ref_mem[a][7:0]};
    end else e.mode = 2'd3;
    sb.push_back(e);
  endtask

  // Monitor: compare registered outputs one cycle after each sampled command
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        expT e;
        e = sb.pop_front();
        check(e.tag, "mode", {14'd0, mode}, {14'd0, e.mode});
        check(e.tag, "laneOe", {14'd0, laneOe}, {14'd0, e.oe});
        check(e.tag, "dataOut", dataOut, e.data);
        check("R8", "standby", {15'd0, standby}, {15'd0, e.mode == 2'd0});
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = FILL;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "standby", {15'd0, standby}, 16'd1);
    check("R1", "mode", {14'd0, mode}, 16'd0);
    check("R1", "laneOe", {14'd0, laneOe}, 16'd0);
    check("R1", "dataOut", dataOut, 16'd0);
    rstN = 1'b1;

    op(0,1,0,0,0, 8'd5, 16'h0000, "R9 fill read");
    op(0,0,0,0,0, 8'd5, 16'h1234, "R6 write oe low");
    op(0,1,0,0,0, 8'd5, 16'h0000, "R4 full read");
    op(0,0,0,0,1, 8'd5, 16'hEEAB, "R6 low-lane write");
    op(0,1,0,0,0, 8'd5, 16'h0000, "R6 merged read");
    op(0,0,1,1,0, 8'd5, 16'hCD77, "R10 high-lane write");
    op(0,1,0,0,0, 8'd5, 16'h0000, "R10 merged read");
    op(0,1,0,0,1, 8'd5, 16'h0000, "R5 low-only read");
    op(0,1,0,1,0, 8'd5, 16'h0000, "R5 high-only read");
    op(1,0,0,0,0, 8'd5, 16'hFFFF, "R2 ce high write");
    op(0,1,0,0,0, 8'd5, 16'h0000, "R2 unchanged read");
    op(0,0,0,1,1, 8'd5, 16'h0000, "R3 byte deselect write");
    op(0,1,0,0,0, 8'd5, 16'h0000, "R3 unchanged read");
    op(0,1,1,0,0, 8'd5, 16'h0000, "R7 output disabled");
    op(0,1,1,1,0, 8'd5, 16'h0000, "R7 output disabled one lane");
    op(1,1,0,0,0, 8'd5, 16'h0000, "R2 ce high read");
    op(0,1,0,0,0, 8'd9, 16'h0000, "R9 untouched word");
    op(0,0,0,0,1, 8'd9, 16'h0011, "R6 partial write");
    op(0,1,0,0,0, 8'd9, 16'h0000, "R9 unwritten lane kept");
    op(0,0,1,0,0, 8'(DEPTH-1), 16'hBEEF, "R6 top address write");
    op(0,1,0,0,0, 8'(DEPTH-1), 16'h0000, "R4 top address read");
    for (int k = 0; k < 16; k++) begin
      op(0,0,k[0],k[1],k[2] & ~k[1], 8'(k*7), 16'(k*16'h1357), "R6 sweep write");
      op(0,1,0,k[2],0, 8'(k*7), 16'h0000, "R4 sweep read");
    end
    op(1,1,1,1,1, 8'd0, 16'h0000, "R2 idle");
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule